// File: doc/BRIEF.md
# Flash Completion Status Poller

This block sits on the host side of a parallel NOR flash and decides when an embedded program or erase operation has finished. After the command that starts the operation has gone out, the host pulses `start`. The engine then reads the status byte of the flash over a simple request/acknowledge read port until it can give a verdict. It pulses exactly one of `done`, `fail` or `timeout` and returns to idle.

Two completion methods can be chosen at each start. In data-compare mode, status bit 7 is compared with bit 7 of the value that was written. In toggle mode, status bit 6 is compared between consecutive reads. While the operation runs that bit flips on every read, and it stops flipping once the operation ends. In both modes status bit 5 signals that the device has exceeded its internal time limit. Because the operation may still finish between two reads, bit 5 never fails the operation on its own: it forces one more read, and only that read decides. A programmable read budget stops the engine with a separate `timeout` verdict if the status never settles.

Top module: `flash_done_poller`

## Requirements
- R1: After reset `busy`, `rd_req`, `done`, `fail` and `timeout` are all low, and `rd_req` is never high while `busy` is low.
- R2: A `start` pulse sampled while idle raises `busy`, and `rd_req` is high in the next cycle. `rd_req` stays high until a cycle in which `rd_ack` is high. `rd_data` is taken in that cycle.
- R3: With `toggle_mode` = 0, a read whose bit 7 equals bit 7 of `expect_data` ends the operation with `done`. Every verdict pulse is high in the second cycle after the cycle in which the deciding read was acknowledged.
- R4: With `toggle_mode` = 0, a read with a bit 7 mismatch and bit 5 = 1 causes exactly one further read. That read gives `done` if its bit 7 matches and `fail` otherwise. `fail` is never given without such a further read.
- R5: With `toggle_mode` = 1, the first read only records bit 6. Each later read whose bit 6 equals bit 6 of the read before it ends the operation with `done`.
- R6: With `toggle_mode` = 1, a read that cannot complete (the first read, or a read whose bit 6 differs from the one before) and that has bit 5 = 1 causes exactly one further read. That read gives `done` if its bit 6 equals bit 6 of the read before it, and `fail` otherwise.
- R7: The reads of one operation are counted. When a read neither completes nor calls for a further read, and the count has reached `max_polls`, the result is `timeout`. A `max_polls` of 0 behaves as 1. The further read of R4/R6 is always made, even past the budget.
- R8: `done`, `fail` and `timeout` are one-cycle pulses, at most one of them is high at a time, and `busy` is low in the pulse cycle.
- R9: `start`, `toggle_mode`, `expect_data` and `max_polls` are ignored while `busy` is high. The running operation finishes with its own settings and no new operation follows.
- R10: A read that neither completes, nor calls for a further read, nor hits the budget leads to a new read request two cycles after its acknowledge, with no verdict pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin polling (sampled only when idle) |
| toggle_mode | input | 1 | 0 = data-compare on bit 7, 1 = toggle compare on bit 6 |
| expect_data | input | DATA_W | Value that was written; bit 7 is the compare target |
| max_polls | input | CNT_W | Read budget before `timeout` |
| rd_req | output | 1 | Status read request |
| rd_ack | input | 1 | Read acknowledge; `rd_data` valid in the same cycle |
| rd_data | input | DATA_W | Status byte returned by the flash |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: operation completed |
| fail | output | 1 | One-cycle pulse: device reported failure |
| timeout | output | 1 | One-cycle pulse: read budget spent |

## Verification
The first `rd_req` is due in the cycle after `start`. A verdict pulse, or the next `rd_req`, is due in the second cycle after the acknowledge cycle: one register holds the sample, and one registers the verdict. The bench drives and samples on falling edges. It notes the cycle in which it raised `rd_ack` and requires the pulse exactly two cycles later. It also requires the pulse to be gone one cycle after that and `busy` to be low in it. Outcome and read count are predicted from the scripted status sequence before each run, so a late or extra read also shows up as a count mismatch.

// File: rtl/fpoll_pkg.sv
package fpoll_pkg;

  localparam int BIT_DONE_CMP = 7;
  localparam int BIT_TOGGLE   = 6;
  localparam int BIT_OVERTIME = 5;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_EVAL
  } state_t;

  typedef enum logic [1:0] {
    PH_FIRST,
    PH_NORMAL,
    PH_RECHECK
  } phase_t;

  typedef enum logic [2:0] {
    VD_AGAIN,
    VD_RECHECK,
    VD_DONE,
    VD_FAIL,
    VD_TIMEOUT
  } verdict_t;

  // data-compare completion: status bit 7 equals the written bit 7
  function automatic logic data_landed(input logic [7:0] status, input logic exp_bit7);
    return status[BIT_DONE_CMP] == exp_bit7;
  endfunction

  // toggle completion: bit 6 did not flip since the previous read
  function automatic logic toggle_quiet(input logic [7:0] status, input logic prev_bit6);
    return status[BIT_TOGGLE] == prev_bit6;
  endfunction

  function automatic logic overtime(input logic [7:0] status);
    return status[BIT_OVERTIME];
  endfunction

endpackage

// File: rtl/fpoll_counter.sv
module fpoll_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             bump,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             at_limit
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (clear) begin
      count <= '0;
    end else if (bump && count != CNT_MAX) begin
      count <= count + 1'b1;
    end
  end

  // a limit of zero is reached as soon as one read has been made
  assign at_limit = (count >= limit);

endmodule

// File: rtl/fpoll_judge.sv
module fpoll_judge
  import fpoll_pkg::*;
(
  input  logic       toggle_mode,
  input  phase_t     phase,
  input  logic [7:0] status,
  input  logic       exp_bit7,
  input  logic       prev_bit6,
  input  logic       at_limit,
  output verdict_t   verdict
);
  logic finished;
  logic can_finish;

  always_comb begin
    finished   = toggle_mode ? toggle_quiet(status, prev_bit6)
                             : data_landed(status, exp_bit7);
    // in toggle mode the first read has nothing to compare against
    can_finish = !(toggle_mode && phase == PH_FIRST);

    if (phase == PH_RECHECK) begin
      verdict = finished ? VD_DONE : VD_FAIL;
    end else if (can_finish && finished) begin
      verdict = VD_DONE;
    end else if (overtime(status)) begin
      verdict = VD_RECHECK;
    end else if (at_limit) begin
      verdict = VD_TIMEOUT;
    end else begin
      verdict = VD_AGAIN;
    end
  end

endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller
  import fpoll_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              toggle_mode,
  input  logic [DATA_W-1:0] expect_data,
  input  logic [CNT_W-1:0]  max_polls,
  output logic              rd_req,
  input  logic              rd_ack,
  input  logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic              timeout
);
  state_t          state;
  phase_t          phase;
  logic            mode_q;
  logic            exp7_q;
  logic [CNT_W-1:0] limit_q;
  logic [7:0]      sample_q;
  logic            prev6_q;
  logic            done_q, fail_q, tmo_q;

  // named internal events
  logic            launch;
  logic            ack_taken;
  logic            eval_now;
  logic            eval_recheck;
  logic [CNT_W-1:0] reads_made;
  logic            at_limit;
  verdict_t        verdict;

  assign launch       = (state == ST_IDLE) && start;
  assign ack_taken    = (state == ST_REQ) && rd_ack;
  assign eval_now     = (state == ST_EVAL);
  assign eval_recheck = eval_now && (phase == PH_RECHECK);

  fpoll_counter #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (launch),
    .bump     (ack_taken),
    .limit    (limit_q),
    .count    (reads_made),
    .at_limit (at_limit)
  );

  fpoll_judge u_judge (
    .toggle_mode (mode_q),
    .phase       (phase),
    .status      (sample_q),
    .exp_bit7    (exp7_q),
    .prev_bit6   (prev6_q),
    .at_limit    (at_limit),
    .verdict     (verdict)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      phase    <= PH_FIRST;
      mode_q   <= 1'b0;
      exp7_q   <= 1'b0;
      limit_q  <= '0;
      sample_q <= '0;
      prev6_q  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_REQ;
            phase   <= PH_FIRST;
            mode_q  <= toggle_mode;
            exp7_q  <= expect_data[BIT_DONE_CMP];
            limit_q <= max_polls;
          end
        end
        ST_REQ: begin
          if (rd_ack) begin
            sample_q <= rd_data[7:0];
            state    <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          prev6_q <= sample_q[BIT_TOGGLE];
          unique case (verdict)
            VD_AGAIN: begin
              phase <= PH_NORMAL;
              state <= ST_REQ;
            end
            VD_RECHECK: begin
              phase <= PH_RECHECK;
              state <= ST_REQ;
            end
            default: state <= ST_IDLE;
          endcase
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      fail_q <= 1'b0;
      tmo_q  <= 1'b0;
    end else begin
      done_q <= eval_now && (verdict == VD_DONE);
      fail_q <= eval_now && (verdict == VD_FAIL);
      tmo_q  <= eval_now && (verdict == VD_TIMEOUT);
    end
  end

  assign rd_req  = (state == ST_REQ);
  assign busy    = (state != ST_IDLE);
  assign done    = done_q;
  assign fail    = fail_q;
  assign timeout = tmo_q;

endmodule

// File: rtl/flash_done_poller_chk.sv
module flash_done_poller_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_req,
  input logic             rd_ack,
  input logic             busy,
  input logic             done,
  input logic             fail,
  input logic             timeout,
  input logic             eval_now,
  input logic             eval_recheck,
  input logic             at_limit,
  input logic             mode_q,
  input logic [CNT_W-1:0] limit_q
);
  logic any_out;
  assign any_out = done | fail | timeout;

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_req);

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> rd_req);

  assert_done_from_eval_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(eval_now));

  assert_fail_needs_reread_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> $past(eval_recheck));

  assert_timeout_at_budget_R7: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> $past(at_limit && !eval_recheck));

  assert_single_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, fail, timeout}));

  assert_pulse_short_R8: assert property (@(posedge clk) disable iff (!rst_n)
    any_out |=> !any_out);

  assert_outcome_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    any_out |-> !busy);

  assert_settings_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(mode_q) && $stable(limit_q)));

endmodule

bind flash_done_poller flash_done_poller_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_req       (rd_req),
  .rd_ack       (rd_ack),
  .busy         (busy),
  .done         (done),
  .fail         (fail),
  .timeout      (timeout),
  .eval_now     (eval_now),
  .eval_recheck (eval_recheck),
  .at_limit     (at_limit),
  .mode_q       (mode_q),
  .limit_q      (limit_q)
);

// File: tb/flash_done_poller_test.sv
module flash_done_poller_test;
  localparam int DW = 8;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          toggle_mode = 1'b0;
  logic [DW-1:0] expect_data = '0;
  logic [CW-1:0] max_polls = '0;
  logic          rd_req;
  logic          rd_ack = 1'b0;
  logic [DW-1:0] rd_data = '0;
  logic          busy, done, fail, timeout;

  int checks = 0;
  int fails  = 0;
  logic [7:0] resp [16];

  flash_done_poller #(.DATA_W(DW), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .toggle_mode(toggle_mode),
    .expect_data(expect_data), .max_polls(max_polls), .rd_req(rd_req),
    .rd_ack(rd_ack), .rd_data(rd_data), .busy(busy), .done(done),
    .fail(fail), .timeout(timeout)
  );

  initial forever #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // outcome codes: 1 done, 2 fail, 3 timeout
  task automatic predict(input bit m, input bit e7, input int lim,
                         output int oc, output int nr);
    int   ph;
    bit   p6;
    logic [7:0] d;
    ph = 0; p6 = 1'b0; oc = 0; nr = 0;
    while (oc == 0 && nr < 64) begin
      d = resp[(nr > 15) ? 15 : nr];
      nr++;
      if (ph == 2)                         oc = ((m ? d[6] == p6 : d[7] == e7)) ? 1 : 2;
      else if (!m && d[7] == e7)           oc = 1;
      else if (m && ph == 1 && d[6] == p6) oc = 1;
      else if (d[5])                       ph = 2;
      else if (nr >= ((lim == 0) ? 1 : lim)) oc = 3;
      else                                 ph = 1;
      p6 = d[6];
    end
  endtask

  task automatic run_op(input bit m, input logic [7:0] ex, input int lim,
                        input int dly, input bit poke, input string tag);
    int  eoc, enr, reads, ack_k, at_k, got, wt;
    bit  hold_ok;
    predict(m, ex[7], lim, eoc, enr);
    @(negedge clk);
    start = 1'b1; toggle_mode = m; expect_data = ex; max_polls = CW'(lim);
    @(negedge clk);
    start = 1'b0;
    chk(rd_req === 1'b1 && busy === 1'b1, {tag, " R2 first request"}, int'(rd_req), 1);
    reads = 0; ack_k = -100; at_k = -1; got = 0; wt = 0; hold_ok = 1'b1;
    for (int k = 0; k < 600; k++) begin
      if (k > 0) @(negedge clk);
      if (poke && k == 4) begin
        start = 1'b0; toggle_mode = m; max_polls = CW'(lim);
      end
      if (rd_ack) begin
        rd_ack = 1'b0; reads++; ack_k = k - 1;
      end
      got = done ? 1 : fail ? 2 : timeout ? 3 : 0;
      if (got != 0) begin at_k = k; break; end
      if (poke && k == 3) begin
        start = 1'b1; toggle_mode = !m; max_polls = CW'(lim + 7);
      end
      if (rd_req) begin
        if (wt >= dly) begin
          rd_ack = 1'b1; rd_data = resp[(reads > 15) ? 15 : reads]; wt = 0;
        end else begin
          wt++;
        end
      end else if (wt != 0) begin
        hold_ok = 1'b0;
      end
    end
    start = 1'b0;
    chk(got == eoc, {tag, " outcome"}, got, eoc);
    chk(reads == enr, {tag, " read count"}, reads, enr);
    chk(at_k - ack_k == 2, "R3 verdict two cycles after acknowledge", at_k - ack_k, 2);
    chk(hold_ok, "R2 request held until acknowledge", int'(hold_ok), 1);
    chk(busy === 1'b0, "R8 idle during pulse", int'(busy), 0);
    @(negedge clk);
    chk(!(done | fail | timeout), "R8 single-cycle pulse", int'(done | fail | timeout), 0);
    chk(busy === 1'b0 && rd_req === 1'b0, "R9 no follow-on operation", int'(busy), 0);
  endtask

  task automatic fill(input logic [7:0] a, input logic [7:0] b, input int n_a);
    for (int i = 0; i < 16; i++) resp[i] = (i < n_a) ? a : b;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !rd_req && !done && !fail && !timeout, "R1 reset state", int'(busy), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !rd_req, "R1 idle after reset", int'(rd_req), 0);

    // R3: data compare, completes on the third read
    fill(8'h00, 8'h80, 2);
    run_op(1'b0, 8'hFF, 10, 1, 1'b0, "R3 data done");
    // R10: mismatches without bit 5 just poll again
    fill(8'h01, 8'h85, 3);
    run_op(1'b0, 8'h80, 10, 0, 1'b0, "R10 repeat poll");
    // R4: bit 5 with mismatch, reread matches -> done
    fill(8'h20, 8'hA0, 1);
    run_op(1'b0, 8'h80, 10, 2, 1'b0, "R4 reread done");
    // R4: bit 5 with mismatch, reread still mismatches -> fail
    fill(8'h20, 8'h20, 1);
    run_op(1'b0, 8'h80, 10, 0, 1'b0, "R4 reread fail");
    // R5: toggling bit 6 then stable
    for (int i = 0; i < 16; i++) resp[i] = (i < 5) ? ((i % 2) ? 8'h40 : 8'h00) : 8'h40;
    run_op(1'b1, 8'h00, 20, 1, 1'b0, "R5 toggle done");
    // R6: keeps toggling with bit 5 -> fail
    for (int i = 0; i < 16; i++) resp[i] = ((i % 2) ? 8'h60 : 8'h20);
    run_op(1'b1, 8'h00, 20, 0, 1'b0, "R6 toggle fail");
    // R6: bit 5 on first read, then stops toggling -> done
    fill(8'h60, 8'h60, 1);
    run_op(1'b1, 8'h00, 20, 0, 1'b0, "R6 toggle late done");
    // R7: never settles, budget 4 and budget 0
    for (int i = 0; i < 16; i++) resp[i] = ((i % 2) ? 8'h40 : 8'h00);
    run_op(1'b1, 8'h80, 4, 0, 1'b0, "R7 toggle timeout");
    run_op(1'b0, 8'h80, 0, 1, 1'b0, "R7 zero budget");
    // R9: start with other settings while busy is ignored
    fill(8'h00, 8'h80, 3);
    run_op(1'b0, 8'h80, 12, 2, 1'b1, "R9 start ignored");

    // near-exhaustive arithmetic sweep over modes, budgets and sequences
    for (int g = 0; g < 192; g++) begin
      for (int i = 0; i < 16; i++) resp[i] = 8'((g * 29 + i * 53 + g * i * 7) ^ ((i % 2) ? 8'h40 : 8'h00));
      run_op(g[0], 8'(g * 73), (g / 2) % 6, g % 3, 1'b0, g[0] ? "R5/R6/R7 sweep" : "R3/R4/R7 sweep");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule